// File: doc/BRIEF.md
# Arithmetic/Logic Unit with Status Flag Word

This block is the arithmetic and logic stage of a small processor datapath. It combines two operands under one of eight operations: add, add with carry-in, subtract, subtract with borrow-in, AND, OR, XOR and compare. Operands are either 16 bits wide or 8 bits wide, chosen by a size select. The result is combinational, so the block has no latency. The status flags that the operation produces go into a registered flag word. That word also holds three control bits, which only an explicit write can change.

The carry and borrow input of the chained operations is taken from the registered carry flag. A multi-word add or subtract therefore runs as one operation per cycle, with the status write enable asserted on each step. A compare sets the flags exactly as a subtract would, but it marks its result as not to be written back.

Six status flags are produced: carry, overflow, sign, zero, auxiliary (nibble) carry and parity. In byte mode each of them is taken at the 8-bit boundary instead of the 16-bit one.

Top module: `alu_flags_unit`

## Requirements
- R1: While reset is asserted, and after reset until the first write, flags_o reads all zeros.
- R2: Operation codes 0 (add) and 1 (add with carry) give res_o = (a + b + c) modulo 2^width. Here c is the registered carry flag for code 1 and 0 for code 0. The new carry is 1 exactly when the unsigned sum exceeds the width.
- R3: Operation codes 2 (subtract), 3 (subtract with borrow) and 7 (compare) give res_o = (a - b - c) modulo 2^width. Here c is the registered carry flag for code 3 and 0 otherwise. The new carry is 1 exactly when that difference is negative, meaning a borrow occurred.
- R4: After an arithmetic operation, overflow is 1 exactly when the true signed result lies outside the two's-complement range of the operand width.
- R5: Sign equals the top bit of the result at the operand width. Zero is 1 exactly when the result bits at the operand width are all 0.
- R6: Auxiliary carry is 1 on a carry out of bit 3 into bit 4 for an add, or a borrow from bit 4 into bit 3 for a subtract or compare. It is 0 after a logic operation.
- R7: Parity is 1 exactly when the low 8 result bits hold an even number of ones.
- R8: Operation codes 4, 5 and 6 give the bitwise AND, OR and XOR of the operands. Each of them clears carry and overflow.
- R9: With narrow_i = 1, only the low 8 bits of each operand are used, and res_o[15:8] is 0. Carry, overflow and sign are then taken at bit 7.
- R10: A compare (code 7) drives res_valid_o low. Every other code drives it high. Compare updates the flags exactly as a subtract with the same operands would.
- R11: The flag word has carry at bit 0, parity at bit 1, auxiliary carry at bit 2, zero at bit 3, sign at bit 4, overflow at bit 5, direction at bit 6, interrupt enable at bit 7 and trap at bit 8. Bits 5:0 load only on a clock edge with stat_we_i = 1. Bits 8:6 load ctl_i[2:0] only on an edge with ctl_we_i = 1. The control bits have no effect on any result or status flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code (see R2, R3, R8, R10) |
| narrow_i | input | 1 | 1 selects 8-bit operands, 0 selects 16-bit operands |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| stat_we_i | input | 1 | Load status flags from the current operation |
| ctl_we_i | input | 1 | Load the control bits from ctl_i |
| ctl_i | input | 3 | Control bits {trap, interrupt enable, direction} |
| res_o | output | 16 | Combinational result |
| res_valid_o | output | 1 | 1 when the result is meant for write-back |
| flags_o | output | 9 | Registered flag word (layout in R11) |

## Verification
The assertions assume that op_i, narrow_i, the operands and both write enables are known values at every rising edge once reset is released. They also assume that these inputs change only between edges, because the flag checks compare a registered flag against the operation that was presented in the cycle before. The stimulus drives every input on the falling edge and holds the inputs idle during reset. It mixes directed corner operands (sign-boundary, all-ones, nibble-boundary, chained carries and borrows) with pseudo-random operations in which either write enable may be low.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

   typedef enum logic [2:0] {
      OP_ADD = 3'd0,
      OP_ADC = 3'd1,
      OP_SUB = 3'd2,
      OP_SBB = 3'd3,
      OP_AND = 3'd4,
      OP_OR  = 3'd5,
      OP_XOR = 3'd6,
      OP_CMP = 3'd7
   } alu_op_e;

   // packed: first member is the most significant bit
   typedef struct packed {
      logic ovf;
      logic sign;
      logic zero;
      logic aux;
      logic par;
      logic carry;
   } stat_flags_t;

   typedef struct packed {
      logic trap;
      logic ien;
      logic dir;
   } ctl_flags_t;

   localparam int STAT_N   = 6;
   localparam int CTL_N    = 3;
   localparam int FLAG_N   = STAT_N + CTL_N;
   localparam int FB_CARRY = 0;
   localparam int FB_PAR   = 1;
   localparam int FB_AUX   = 2;
   localparam int FB_ZERO  = 3;
   localparam int FB_SIGN  = 4;
   localparam int FB_OVF   = 5;

endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
   import alu_flags_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8
) (
   input  alu_op_e           op,
   input  logic              narrow,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              cf_in,
   output logic [DATA_W-1:0] res,
   output logic              res_valid,
   output logic              carry,
   output logic              ovf,
   output logic              aux
);
   localparam int EXT_W  = DATA_W + 1;
   localparam int HIGH_W = DATA_W - NARROW_W;

   logic [DATA_W-1:0] mask, a_m, b_m, b_x, sum_r, logic_r;
   logic [EXT_W-1:0]  sum_ext;
   logic              is_sub, is_logic, use_cin, cin, cout;
   logic              msb_a, msb_bx, msb_r;

   always_comb begin
      mask     = narrow ? {{HIGH_W{1'b0}}, {NARROW_W{1'b1}}} : {DATA_W{1'b1}};
      a_m      = a & mask;
      b_m      = b & mask;
      is_sub   = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
      is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
      use_cin  = (op == OP_ADC) || (op == OP_SBB);
      // subtract as add of the inverted operand; borrow is an inverted carry
      b_x      = is_sub ? (~b & mask) : b_m;
      cin      = is_sub ? ~(use_cin & cf_in) : (use_cin & cf_in);
      sum_ext  = {1'b0, a_m} + {1'b0, b_x} + EXT_W'(cin);
      sum_r    = sum_ext[DATA_W-1:0] & mask;
      cout     = narrow ? sum_ext[NARROW_W] : sum_ext[DATA_W];
      msb_a    = narrow ? a_m[NARROW_W-1] : a_m[DATA_W-1];
      msb_bx   = narrow ? b_x[NARROW_W-1] : b_x[DATA_W-1];
      msb_r    = narrow ? sum_r[NARROW_W-1] : sum_r[DATA_W-1];

      case (op)
         OP_AND:  logic_r = a_m & b_m;
         OP_OR:   logic_r = a_m | b_m;
         OP_XOR:  logic_r = a_m ^ b_m;
         default: logic_r = '0;
      endcase

      res       = is_logic ? logic_r : sum_r;
      res_valid = (op != OP_CMP);
      carry     = !is_logic && (cout ^ is_sub);
      ovf       = !is_logic && (msb_a == msb_bx) && (msb_r != msb_a);
      // carry or borrow across the nibble boundary, same form for both
      aux       = !is_logic && (a_m[4] ^ b_m[4] ^ sum_r[4]);
   end

endmodule

// File: rtl/alu_status.sv
module alu_status #(
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8,
   parameter int PAR_W    = 8
) (
   input  logic [DATA_W-1:0] res,
   input  logic              narrow,
   output logic              sign,
   output logic              zero,
   output logic              par
);
   logic [PAR_W:0] chain;

   assign chain[0] = 1'b1;
   for (genvar gi = 0; gi < PAR_W; gi++) begin : g_par
      assign chain[gi+1] = chain[gi] ^ res[gi];
   end
   assign par = chain[PAR_W];

   always_comb begin
      sign = narrow ? res[NARROW_W-1] : res[DATA_W-1];
      zero = narrow ? (res[NARROW_W-1:0] == '0) : (res == '0);
   end

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
   import alu_flags_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               stat_we,
   input  stat_flags_t        stat_d,
   input  logic               ctl_we,
   input  logic [CTL_N-1:0]   ctl_d,
   output logic [FLAG_N-1:0]  flags
);
   stat_flags_t      stat_q;
   logic [CTL_N-1:0] ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       stat_q <= '0;
      else if (stat_we) stat_q <= stat_d;
   end

   for (genvar gi = 0; gi < CTL_N; gi++) begin : g_ctl
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      ctl_q[gi] <= 1'b0;
         else if (ctl_we) ctl_q[gi] <= ctl_d[gi];
      end
   end

   assign flags = {ctl_q, stat_q};

   assert_stat_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_we |=> $stable(flags[STAT_N-1:0]));
   assert_ctl_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_we |=> $stable(flags[FLAG_N-1:STAT_N]));
   assert_ctl_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we |=> flags[FLAG_N-1:STAT_N] == $past(ctl_d));

endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
   import alu_flags_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8,
   parameter int PAR_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        op_i,
   input  logic              narrow_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              stat_we_i,
   input  logic              ctl_we_i,
   input  logic [2:0]        ctl_i,
   output logic [DATA_W-1:0] res_o,
   output logic              res_valid_o,
   output logic [8:0]        flags_o
);
   if (NARROW_W < 8 || NARROW_W >= DATA_W) begin : g_bad_narrow
      $error("alu_flags_unit: NARROW_W must be at least 8 and below DATA_W");
   end
   if (PAR_W > NARROW_W) begin : g_bad_par
      $error("alu_flags_unit: PAR_W must not exceed NARROW_W");
   end

   alu_op_e     op;
   stat_flags_t stat_n;
   logic [DATA_W-1:0] res_w;
   logic carry_w, ovf_w, aux_w, sign_w, zero_w, par_w;

   assign op = alu_op_e'(op_i);

   alu_datapath #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_dp (
      .op(op), .narrow(narrow_i), .a(a_i), .b(b_i), .cf_in(flags_o[FB_CARRY]),
      .res(res_w), .res_valid(res_valid_o), .carry(carry_w), .ovf(ovf_w), .aux(aux_w)
   );

   alu_status #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .PAR_W(PAR_W)) u_st (
      .res(res_w), .narrow(narrow_i), .sign(sign_w), .zero(zero_w), .par(par_w)
   );

   always_comb begin
      stat_n.carry = carry_w;
      stat_n.par   = par_w;
      stat_n.aux   = aux_w;
      stat_n.zero  = zero_w;
      stat_n.sign  = sign_w;
      stat_n.ovf   = ovf_w;
   end

   alu_flag_reg u_fr (
      .clk(clk), .rst_n(rst_n), .stat_we(stat_we_i), .stat_d(stat_n),
      .ctl_we(ctl_we_i), .ctl_d(ctl_i), .flags(flags_o)
   );

   assign res_o = res_w;

   assert_add_wide_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 3'd0 && !narrow_i) |-> ({carry_w, res_o} == ({1'b0, a_i} + {1'b0, b_i})));
   assert_sub_borrow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 3'd2 && !narrow_i) |-> (carry_w == (a_i < b_i)));
   assert_logic_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_we_i && (op_i == 3'd4 || op_i == 3'd5 || op_i == 3'd6))
      |=> (!flags_o[FB_CARRY] && !flags_o[FB_OVF]));
   assert_parity_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stat_we_i |=> flags_o[FB_PAR] == ~^$past(res_o[PAR_W-1:0]));
   assert_zero_wide_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_we_i && !narrow_i) |=> flags_o[FB_ZERO] == ($past(res_o) == '0));
   assert_narrow_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
      narrow_i |-> (res_o[DATA_W-1:NARROW_W] == '0));
   assert_cmp_sub_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 3'd7) |-> (!res_valid_o && res_o == ((a_i - b_i) &
         (narrow_i ? {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}} : {DATA_W{1'b1}}))));

endmodule

// File: tb/alu_flags_unit_test.sv
`timescale 1ns/1ps
module alu_flags_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  op_i = '0;
   logic        narrow_i = 1'b0;
   logic [15:0] a_i = '0, b_i = '0;
   logic        stat_we_i = 1'b0, ctl_we_i = 1'b0;
   logic [2:0]  ctl_i = '0;
   logic [15:0] res_o;
   logic        res_valid_o;
   logic [8:0]  flags_o;

   int total = 0;
   int bad = 0;
   bit done = 0;
   logic [8:0] mflags = '0;

   always #2 clk = ~clk;

   alu_flags_unit uut (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .narrow_i(narrow_i), .a_i(a_i), .b_i(b_i),
      .stat_we_i(stat_we_i), .ctl_we_i(ctl_we_i), .ctl_i(ctl_i),
      .res_o(res_o), .res_valid_o(res_valid_o), .flags_o(flags_o)
   );

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // returns {valid, ovf, sign, zero, aux, par, carry, result[15:0]}
   function automatic logic [22:0] model(input int op, input bit nb, input int a, input int b, input bit cf);
      int w = nb ? 8 : 16;
      int mask = (1 << w) - 1;
      int av = a & mask;
      int bv = b & mask;
      int ci = (op == 1 || op == 3) ? int'(cf) : 0;
      int s, r, sa, sb, sr;
      bit c, o, x, sg, z, p;
      sa = (av >> (w-1)) & 1;
      sb = (bv >> (w-1)) & 1;
      if (op <= 1) begin
         s = av + bv + ci; r = s & mask; c = (s > mask);
         sr = (r >> (w-1)) & 1;
         o = (sa == sb) && (sr != sa);
         x = ((av & 15) + (bv & 15) + ci) > 15;
      end else if (op <= 3 || op == 7) begin
         s = av - bv - ci; r = s & mask; c = (s < 0);
         sr = (r >> (w-1)) & 1;
         o = (sa != sb) && (sr != sa);
         x = ((av & 15) - (bv & 15) - ci) < 0;
      end else begin
         r = (op == 4) ? (av & bv) : (op == 5) ? (av | bv) : (av ^ bv);
         c = 0; o = 0; x = 0;
      end
      sg = (r >> (w-1)) & 1;
      z = (r == 0);
      p = ($countones(r & 255) % 2) == 0;
      return {bit'(op != 7), o, sg, z, x, p, c, r[15:0]};
   endfunction

   function automatic string op_req(input int op);
      if (op <= 1) return "R2";
      if (op == 7) return "R10";
      if (op <= 3) return "R3";
      return "R8";
   endfunction

   task automatic step(input int op, input bit nb, input int a, input int b,
                       input bit fwe, input bit cwe, input int cv);
      logic [22:0] m;
      string rq;
      @(negedge clk);
      op_i = op[2:0]; narrow_i = nb; a_i = a[15:0]; b_i = b[15:0];
      stat_we_i = fwe; ctl_we_i = cwe; ctl_i = cv[2:0];
      #1;
      m = model(op, nb, a, b, mflags[0]);
      rq = nb ? "R9" : op_req(op);
      chk(res_o == m[15:0], rq, "result", res_o, m[15:0]);
      chk(res_valid_o == m[22], "R10", "res_valid", res_valid_o, m[22]);
      @(posedge clk);
      if (fwe) mflags[5:0] = m[21:16];
      if (cwe) mflags[8:6] = cv[2:0];
      #1;
      chk(flags_o[0] == mflags[0], fwe ? (nb ? "R9" : op_req(op)) : "R11", "carry", flags_o[0], mflags[0]);
      chk(flags_o[1] == mflags[1], "R7", "parity", flags_o[1], mflags[1]);
      chk(flags_o[2] == mflags[2], "R6", "aux", flags_o[2], mflags[2]);
      chk(flags_o[3] == mflags[3], "R5", "zero", flags_o[3], mflags[3]);
      chk(flags_o[4] == mflags[4], "R5", "sign", flags_o[4], mflags[4]);
      chk(flags_o[5] == mflags[5], "R4", "overflow", flags_o[5], mflags[5]);
      chk(flags_o[8:6] == mflags[8:6], "R11", "control", flags_o[8:6], mflags[8:6]);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk(flags_o == 9'd0, "R1", "flags in reset", flags_o, 0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(flags_o == 9'd0, "R1", "flags after reset", flags_o, 0);
      // R2 / R4 corners
      step(0, 0, 16'h7FFF, 16'h0001, 1, 0, 0);
      step(0, 0, 16'hFFFF, 16'h0001, 1, 0, 0);
      step(1, 0, 16'h1234, 16'h0000, 1, 0, 0);  // uses carry from previous add
      step(0, 0, 16'h000F, 16'h0001, 1, 0, 0);  // R6 nibble carry
      // R3 corners
      step(2, 0, 16'h0000, 16'h0001, 1, 0, 0);
      step(3, 0, 16'h0005, 16'h0002, 1, 0, 0);  // borrow in
      step(2, 0, 16'h8000, 16'h0001, 1, 0, 0);
      step(2, 0, 16'h0010, 16'h0001, 1, 0, 0);  // R6 nibble borrow
      // R10 compare
      step(7, 0, 16'h0003, 16'h0003, 1, 0, 0);
      step(7, 1, 16'hAB03, 16'h1204, 1, 0, 0);
      // R9 byte mode with garbage high bytes
      step(0, 1, 16'hA57F, 16'h3C01, 1, 0, 0);
      step(0, 1, 16'h12FF, 16'h3401, 1, 0, 0);
      step(2, 1, 16'hFF80, 16'h0001, 1, 0, 0);
      // R8 logic ops after a carry
      step(0, 0, 16'hFFFF, 16'hFFFF, 1, 0, 0);
      step(4, 0, 16'hF0F0, 16'h0FF0, 1, 0, 0);
      step(5, 1, 16'hFF00, 16'h0081, 1, 0, 0);
      step(6, 0, 16'hAAAA, 16'hAAAA, 1, 0, 0);
      // R11 write enables and control bits
      step(0, 0, 16'hFFFF, 16'h0001, 0, 1, 5);
      step(2, 0, 16'h0000, 16'h0001, 1, 1, 2);
      step(1, 0, 16'h0001, 16'h0001, 0, 0, 7);
      step(0, 0, 16'h8000, 16'h8000, 1, 1, 7);
      for (int i = 0; i < 800; i++) begin
         int r = $urandom;
         step($urandom % 8, r[0], $urandom & 16'hFFFF, $urandom & 16'hFFFF,
              r[1] | r[2], r[3] & r[4], r[7:5]);
      end
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule